// File: doc/BRIEF.md
# Scan-Slice Code Decompressor

This block turns a stream of compact slice codes into full-width scan slices, one bit per parallel scan chain. Each code is K+2 bits wide, where K = ceil(log2(N+1)) and N is the number of chains. A two-bit control field says how the code is read, and a K-bit data field carries either a bit index or a group of literal bits. A slice is built in an internal N-bit buffer from a variable number of codes. A start code fixes the default fill of the whole slice. Later codes mark single bits with the opposite value, or copy a K-bit literal group into place.

A finished slice leaves through a valid/ready output. It is released when the next start code arrives, or when the test source raises the end-of-stream flag while no code is offered. While a finished slice waits to be taken, the code input is held off.

Top module: `scan_slice_decomp`

## Requirements
- R1: The control field is `code_word[K+1:K]` and the data field is `code_word[K-1:0]`, with K = ceil(log2(N+1)). Slice bit index 0 is the leftmost bit and appears on `slice_data[N-1]`; index i appears on `slice_data[N-1-i]`.
- R2: Control 00 opens a new slice with every bit 0, then sets the indexed bit to 1.
- R3: Control 01 opens a new slice with every bit 1, then clears the indexed bit to 0.
- R4: Control 10, inside an open slice, sets the indexed bit to the opposite of that slice's fill value.
- R5: Control 11, inside an open slice, takes its data as a group start index s. The next accepted code, whatever its control field, is group data: its data MSB goes to bit s, and the following data bits go to bits s+1 and onward, up to s+K-1.
- R6: In a group copy, positions at N or beyond are not written, so a short last group gets only the bits that exist.
- R7: An index of N or more in a 00, 01 or 10 code changes no bit. A start code then gives a slice that is all fill.
- R8: A start code accepted while a slice is open presents the previous slice on `slice_data` with `slice_valid` high from the next cycle.
- R9: `stream_end` high while `code_valid` is low and `code_ready` is high outputs the open slice and closes it. With no slice open it produces no output.
- R10: `code_ready` is low exactly while `slice_valid` is high. A pending slice keeps its value until `slice_ready` takes it.
- R11: 10 and 11 codes arriving with no slice open are ignored, and a 11 code ignored this way does not capture the following code as group data.
- R12: After reset `slice_valid` is 0, `code_ready` is 1 and no slice is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_valid | input | 1 | A code is offered |
| code_ready | output | 1 | Decoder accepts a code or end flag |
| code_word | input | K+2 | Control field and data field |
| stream_end | input | 1 | Flush the open slice (acts when no code is offered) |
| slice_valid | output | 1 | A finished slice is presented |
| slice_ready | input | 1 | Downstream takes the slice |
| slice_data | output | N | Finished slice, index 0 at MSB |

## Verification
A fixed code stream covers both fill polarities, marks at the first, middle and last index, and the out-of-range index N. Each expected slice therefore separates a wrong fill from a wrong bit mapping. Group copies are tried with a full group at index 0, a truncated group at index 6, and a start index beyond the slice. The second group code carries a start-code control field, which shows whether group data is wrongly read as a new slice. Directed cases then cover marks and groups sent while no slice is open, an end flag with nothing to flush, a reset that discards an open slice, and a held output that must stall the code input and keep its value.

// File: rtl/sscd_pkg.sv
package sscd_pkg;

    typedef enum logic [1:0] {
        CTL_FILL0 = 2'b00,
        CTL_FILL1 = 2'b01,
        CTL_MARK  = 2'b10,
        CTL_GROUP = 2'b11
    } ctl_e;

    function automatic int index_bits(input int n);
        return $clog2(n + 1);
    endfunction

    function automatic logic is_start(input ctl_e c);
        return (c == CTL_FILL0) || (c == CTL_FILL1);
    endfunction

endpackage

// File: rtl/sscd_code_split.sv
module sscd_code_split
    import sscd_pkg::*;
#(
    parameter int K = 4,
    localparam int C = K + 2
) (
    input  logic [C-1:0] word_i,
    output ctl_e         ctl_o,
    output logic [K-1:0] data_o
);

    assign ctl_o  = ctl_e'(word_i[C-1:C-2]);
    assign data_o = word_i[K-1:0];

endmodule

// File: rtl/sscd_assembler.sv
module sscd_assembler
    import sscd_pkg::*;
#(
    parameter int N = 8,
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take_i,
    input  logic         flush_i,
    input  ctl_e         ctl_i,
    input  logic [K-1:0] data_i,
    output logic         emit_o,
    output logic [N-1:0] emit_slice_o
);

    typedef struct packed {
        logic [N-1:0] bits;
        logic         open;
        logic         fill;
        logic         pend;
        logic [K-1:0] gstart;
    } asm_state_t;

    asm_state_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        emit_o = 1'b0;
        if (take_i) begin
            if (st_q.pend) begin
                for (int p = 0; p < N; p++) begin
                    for (int j = 0; j < K; j++) begin
                        if (p == int'(st_q.gstart) + j)
                            st_d.bits[N-1-p] = data_i[K-1-j];
                    end
                end
                st_d.pend = 1'b0;
            end else begin
                unique case (ctl_i)
                    CTL_FILL0, CTL_FILL1: begin
                        emit_o     = st_q.open;
                        st_d.open  = 1'b1;
                        st_d.fill  = ctl_i[0];
                        st_d.bits  = {N{ctl_i[0]}};
                        for (int p = 0; p < N; p++) begin
                            if (p == int'(data_i))
                                st_d.bits[N-1-p] = ~ctl_i[0];
                        end
                    end
                    CTL_MARK: begin
                        if (st_q.open) begin
                            for (int p = 0; p < N; p++) begin
                                if (p == int'(data_i))
                                    st_d.bits[N-1-p] = ~st_q.fill;
                            end
                        end
                    end
                    CTL_GROUP: begin
                        if (st_q.open) begin
                            st_d.pend   = 1'b1;
                            st_d.gstart = data_i;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (flush_i) begin
            emit_o    = st_q.open;
            st_d.open = 1'b0;
            st_d.pend = 1'b0;
        end
    end

    assign emit_slice_o = st_q.bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2 / R7: a zero-fill start with an out-of-range index leaves all zeros
    assert_fill0_blank_R7: assert property (@(posedge clk) disable iff (rst)
        (take_i && !st_q.pend && ctl_i == CTL_FILL0 && int'(data_i) >= N)
        |=> (st_q.bits == '0));

    // R11: a mark with no open slice leaves the buffer untouched
    assert_mark_closed_R11: assert property (@(posedge clk) disable iff (rst)
        (take_i && !st_q.pend && !st_q.open && ctl_i == CTL_MARK)
        |=> $stable(st_q.bits) && !st_q.open);

    // R9: a flush closes the slice
    assert_flush_closes_R9: assert property (@(posedge clk) disable iff (rst)
        (flush_i && !take_i) |=> !st_q.open);

    // R5: a pending group is always consumed by the next accepted code
    assert_group_consumed_R5: assert property (@(posedge clk) disable iff (rst)
        (take_i && st_q.pend) |=> !st_q.pend && st_q.open);

endmodule

// File: rtl/sscd_out_stage.sv
module sscd_out_stage #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         emit_i,
    input  logic [N-1:0] slice_i,
    input  logic         ready_i,
    output logic         valid_o,
    output logic [N-1:0] data_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else if (emit_i) begin
            valid_o <= 1'b1;
            data_o  <= slice_i;
        end else if (valid_o && ready_i) begin
            valid_o <= 1'b0;
        end
    end

    // R10: a held slice stays presented and unchanged
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i) |=> valid_o && $stable(data_o));

endmodule

// File: rtl/scan_slice_decomp.sv
module scan_slice_decomp
    import sscd_pkg::*;
#(
    parameter  int N = 8,
    localparam int K = index_bits(N),
    localparam int C = K + 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         code_valid,
    output logic         code_ready,
    input  logic [C-1:0] code_word,
    input  logic         stream_end,
    output logic         slice_valid,
    input  logic         slice_ready,
    output logic [N-1:0] slice_data
);

    ctl_e         ctl;
    logic [K-1:0] data;
    logic         take, flush, emit;
    logic [N-1:0] emit_slice;

    assign code_ready = ~slice_valid;
    assign take       = code_valid & code_ready;
    assign flush      = stream_end & ~code_valid & code_ready;

    sscd_code_split #(.K(K)) u_split (
        .word_i (code_word),
        .ctl_o  (ctl),
        .data_o (data)
    );

    sscd_assembler #(.N(N), .K(K)) u_asm (
        .clk          (clk),
        .rst          (rst),
        .take_i       (take),
        .flush_i      (flush),
        .ctl_i        (ctl),
        .data_i       (data),
        .emit_o       (emit),
        .emit_slice_o (emit_slice)
    );

    sscd_out_stage #(.N(N)) u_out (
        .clk     (clk),
        .rst     (rst),
        .emit_i  (emit),
        .slice_i (emit_slice),
        .ready_i (slice_ready),
        .valid_o (slice_valid),
        .data_o  (slice_data)
    );

    // R10: the code input is stalled while a slice waits
    assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
        slice_valid |-> !code_ready);

    // R8: a start code accepted over an open slice yields an output next cycle
    assert_emit_on_start_R8: assert property (@(posedge clk) disable iff (rst)
        emit |=> slice_valid);

endmodule

// File: tb/scan_slice_decomp_bench.sv
module scan_slice_decomp_bench;

    localparam int N  = 8;
    localparam int K  = 4;
    localparam int C  = 6;
    localparam int NS = 20;
    localparam int NE = 9;

    // bit 6 set = end-of-stream flag; otherwise {ctl[1:0], data[3:0]}
    localparam logic [6:0] STREAM [NS] = '{
        7'b0_00_0101,
        7'b0_00_0111, 7'b0_11_0000, 7'b0_11_1110,
        7'b0_01_1000,
        7'b0_00_1000,
        7'b0_01_0100,
        7'b0_00_0000, 7'b0_10_0111, 7'b0_10_0011,
        7'b0_01_0010, 7'b0_10_0110, 7'b0_10_1000,
        7'b0_00_1000, 7'b0_11_0110, 7'b0_01_1011,
        7'b0_01_1000, 7'b0_11_1000, 7'b0_00_1111,
        7'b1_00_0000
    };

    localparam logic [7:0] EXPECT [NE] = '{
        8'b00000100,  // R2 mark at index 5
        8'b11100001,  // R5 full group at 0, R2 mark at last index
        8'b11111111,  // R7 one-fill with index N
        8'b00000000,  // R7 zero-fill with index N
        8'b11110111,  // R3 clear at index 4
        8'b10010001,  // R4 marks on zero fill
        8'b11011101,  // R4 marks on one fill, R7 mark index N
        8'b00000010,  // R6 truncated group, control of data code ignored
        8'b11111111   // R6 group start beyond slice, R9 flush
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         code_valid = 1'b0;
    logic         code_ready;
    logic [C-1:0] code_word = '0;
    logic         stream_end = 1'b0;
    logic         slice_valid;
    logic         slice_ready = 1'b1;
    logic [N-1:0] slice_data;

    int checks = 0;
    int errors = 0;
    int got_n  = 0;
    logic [N-1:0] got [32];

    always #2.5 clk = ~clk;

    scan_slice_decomp #(.N(N)) u_scan_slice_decomp (
        .clk         (clk),
        .rst         (rst),
        .code_valid  (code_valid),
        .code_ready  (code_ready),
        .code_word   (code_word),
        .stream_end  (stream_end),
        .slice_valid (slice_valid),
        .slice_ready (slice_ready),
        .slice_data  (slice_data)
    );

    always @(negedge clk) begin
        if (!rst && slice_valid && slice_ready && got_n < 32) begin
            got[got_n] = slice_data;
            got_n = got_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] ctl, input logic [3:0] dat);
        @(negedge clk);
        while (!code_ready) @(negedge clk);
        code_valid = 1'b1;
        code_word  = {ctl, dat};
        @(negedge clk);
        code_valid = 1'b0;
    endtask

    task automatic finish_stream();
        @(negedge clk);
        while (!code_ready) @(negedge clk);
        stream_end = 1'b1;
        @(negedge clk);
        stream_end = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int base;
        logic [N-1:0] held;

        idle(3);
        // R12: reset state
        check("R12 valid", 32'(slice_valid), 32'd0);
        check("R12 ready", 32'(code_ready), 32'd1);
        rst = 1'b0;
        idle(2);
        check("R12 valid after release", 32'(slice_valid), 32'd0);

        // main stream from the table
        for (int i = 0; i < NS; i++) begin
            if (STREAM[i][6]) finish_stream();
            else send(STREAM[i][5:4], STREAM[i][3:0]);
        end
        idle(4);
        check("R8 R9 slice count", 32'(got_n), 32'(NE));
        for (int i = 0; i < NE; i++)
            check($sformatf("R1 R2-R9 slice %0d", i), 32'(got[i]), 32'(EXPECT[i]));

        // R11: marks and groups with no open slice, then empty flush
        base = got_n;
        send(2'b10, 4'd0);
        send(2'b11, 4'd0);
        finish_stream();
        idle(4);
        check("R9 R11 no output without open slice", 32'(got_n), 32'(base));
        // the ignored 11 must not swallow this start code
        send(2'b00, 4'd1);
        finish_stream();
        idle(4);
        check("R11 start not captured as group data", 32'(got_n), 32'(base + 1));
        check("R11 slice value", 32'(got[base]), 32'h40);

        // R10: backpressure
        slice_ready = 1'b0;
        send(2'b00, 4'd0);
        send(2'b00, 4'd1);
        idle(2);
        check("R10 valid held", 32'(slice_valid), 32'd1);
        check("R10 ready low", 32'(code_ready), 32'd0);
        held = slice_data;
        check("R10 held value", 32'(held), 32'h80);
        idle(5);
        check("R10 still held", 32'(slice_data), 32'(held));
        check("R10 ready still low", 32'(code_ready), 32'd0);
        base = got_n;
        slice_ready = 1'b1;
        idle(2);
        check("R10 taken once", 32'(got_n), 32'(base + 1));
        check("R10 ready back", 32'(code_ready), 32'd1);
        finish_stream();
        idle(4);
        check("R10 R9 flushed after stall", 32'(got[got_n-1]), 32'h40);

        // R12: reset discards an open slice
        base = got_n;
        send(2'b01, 4'd8);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        finish_stream();
        idle(4);
        check("R12 open slice cleared by reset", 32'(got_n), 32'(base));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule